// File: doc/BRIEF.md
# Loop Aggregation Iteration Unit

This unit sits between an in-order issue stage and a group of parallel functional units. Issue hands it one decoded primary instruction per handshake. The instruction comes with a requested loop factor and a flag that tells whether it belongs to a dependent (sequence) region or to an independent (vector) region of the loop body.

For a vector instruction the unit unrolls the loop in hardware. It emits one secondary copy per loop iteration, in iteration order. Each copy rewrites its iteration-local register operands so that they point into a hidden bank of extended registers. Registers that the body only reads keep their architected numbers.

The unit also turns the index-initialisation instruction into per-iteration immediate loads. Sequence instructions pass through as a single unchanged copy. Up to `LANES` copies can leave in one cycle, limited by a configured parallelism bound. The next primary instruction is accepted only when the current one has been fully expanded, so program order holds at the functional units.

Top module: `lagg_iter_unit`

## Requirements
- R1: A vector primary instruction yields exactly F secondary copies, carrying iteration numbers 0 to F-1 in ascending order. The last flag is set on copy F-1 and on no other copy.
- R2: A register r is iteration-local when r <= `cfg_last_dyn`. In the copy for iteration j, such an operand becomes extended register r*F + j with its `_x` flag at 1. Any other operand keeps its architected number, zero-extended, with its `_x` flag at 0.
- R3: The effective F is computed as follows. A request of 0 counts as 1. The request is then limited to min(MAX_F, NUM_XREG / (`cfg_last_dyn`+1)), using integer division. The factor in force is the one seen at acceptance.
- R4: The index-initialisation opcode is 15. When its destination is iteration-local, it expands into F copies with opcode 14 (set-immediate), the remapped destination, and immediate j.
- R5: An index-initialisation instruction whose destination is not iteration-local yields one copy with opcode 14 and immediate 0. That copy has iteration 0, the last flag set, and the architected destination.
- R6: An instruction with `in_seq`=1 yields one copy. Its opcode, immediate and register numbers are unchanged, all `_x` flags are 0, its iteration is 0, and its last flag is set.
- R7: Each output beat holds min(P, copies remaining) copies. P is `cfg_par_limit` clamped to 1..LANES, with 0 treated as 1. Valid lanes are contiguous from lane 0 and carry consecutive iterations.
- R8: `in_ready` is low while an expansion is pending. The one exception is the cycle in which its final beat is taken. An accepted instruction appears at the output in the next cycle.
- R9: While `out_valid` is high and `out_ready` is low, every output holds its value into the next cycle.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_last_dyn | input | 4 | Highest iteration-local architected register |
| cfg_par_limit | input | LW | Parallelism bound shared by the loop's units |
| in_valid | input | 1 | Primary instruction offered |
| in_ready | output | 1 | Primary instruction taken this cycle if valid |
| in_seq | input | 1 | Instruction belongs to a sequence region |
| in_op | input | 4 | Opcode (15 = index initialisation) |
| in_rd | input | 4 | Destination register |
| in_rs1 | input | 4 | First source register |
| in_rs2 | input | 4 | Second source register |
| in_imm | input | 8 | Immediate |
| in_factor | input | FW | Requested loop factor |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_lane_vld | output | LANES | Per-lane copy valid |
| out_op | output | LANES x 4 | Copy opcode |
| out_dst | output | LANES x 6 | Copy destination index |
| out_src1 | output | LANES x 6 | Copy first source index |
| out_src2 | output | LANES x 6 | Copy second source index |
| out_dst_x | output | LANES | Destination is an extended register |
| out_src1_x | output | LANES | First source is an extended register |
| out_src2_x | output | LANES | Second source is an extended register |
| out_imm | output | LANES x 8 | Copy immediate |
| out_iter | output | LANES x IW | Iteration number of the copy |
| out_last | output | LANES | Copy is the final one of its primary |

## Verification
The bench covers several factor limits:
- requests of 0, requests above the register-derived cap, and caps of 16, 8 and 4 copies. A wrong divider or clamp shows up as a short or long run of copies.
- parallelism bounds of 0, 3, 4 and above LANES, under a randomly throttled `out_ready`. A unit that splits beats wrongly puts the last flag in the wrong lane or skips iterations.
- an index initialisation on a static destination, and sequence instructions placed in between vector ones. A unit that expands either of these produces extra copies or sets extended flags.
- back-to-back acceptance on the final beat and held stalls. These expose lost or duplicated instructions and outputs that change during a stall.

// File: rtl/lagg_pkg.sv
package lagg_pkg;
    localparam int AREG_W = 4;
    localparam int XREG_W = 6;
    localparam int OP_W   = 4;
    localparam int IMM_W  = 8;

    localparam logic [OP_W-1:0] OP_INDEX = 4'hF;
    localparam logic [OP_W-1:0] OP_SETI  = 4'hE;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [AREG_W-1:0] rd;
        logic [AREG_W-1:0] rs1;
        logic [AREG_W-1:0] rs2;
        logic [IMM_W-1:0]  imm;
    } prim_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [XREG_W-1:0] dst;
        logic [XREG_W-1:0] src1;
        logic [XREG_W-1:0] src2;
        logic              dst_x;
        logic              src1_x;
        logic              src2_x;
        logic [IMM_W-1:0]  imm;
    } sec_t;
endpackage

// File: rtl/lagg_factor.sv
module lagg_factor
    import lagg_pkg::*;
#(
    parameter int MAX_F    = 16,
    parameter int NUM_XREG = 64,
    parameter int FW       = 5
) (
    input  logic [AREG_W-1:0] last_dyn,
    input  logic [FW-1:0]     f_req,
    output logic [FW-1:0]     f_eff
);
    localparam int CW = $clog2(NUM_XREG + 1);

    logic [CW-1:0] dyn_cnt;
    logic [CW-1:0] cap_raw;
    logic [FW-1:0] cap;
    logic [FW-1:0] f_min1;

    always_comb begin
        dyn_cnt = CW'(last_dyn) + CW'(1);
        cap_raw = CW'(NUM_XREG) / dyn_cnt;
        cap     = (cap_raw > CW'(MAX_F)) ? FW'(MAX_F) : cap_raw[FW-1:0];
        f_min1  = (f_req == '0) ? FW'(1) : f_req;
        f_eff   = (f_min1 > cap) ? cap : f_min1;
    end
endmodule

// File: rtl/lagg_remap.sv
module lagg_remap
    import lagg_pkg::*;
#(
    parameter int FW = 5
) (
    input  logic              en,
    input  logic [AREG_W-1:0] areg,
    input  logic [AREG_W-1:0] last_dyn,
    input  logic [FW-1:0]     f,
    input  logic [FW-1:0]     j,
    output logic [XREG_W-1:0] idx,
    output logic              ext
);
    localparam int MW = AREG_W + FW;

    logic [MW-1:0] slot_full;
    logic [MW-XREG_W-1:0] unused_hi;

    always_comb begin
        slot_full = MW'(areg) * MW'(f) + MW'(j);
        unused_hi = slot_full[MW-1:XREG_W];
        ext       = en && (areg <= last_dyn);
        idx       = ext ? slot_full[XREG_W-1:0] : XREG_W'(areg);
    end
endmodule

// File: rtl/lagg_lane.sv
module lagg_lane
    import lagg_pkg::*;
#(
    parameter int FW = 5
) (
    input  prim_t             ins,
    input  logic              seq,
    input  logic [AREG_W-1:0] last_dyn,
    input  logic [FW-1:0]     f,
    input  logic [FW-1:0]     iter,
    output sec_t              slot
);
    logic              is_idx;
    logic [XREG_W-1:0] d_idx, s1_idx, s2_idx;
    logic              d_x, s1_x, s2_x;

    lagg_remap #(.FW(FW)) u_dst (
        .en(!seq), .areg(ins.rd), .last_dyn(last_dyn), .f(f), .j(iter),
        .idx(d_idx), .ext(d_x)
    );
    lagg_remap #(.FW(FW)) u_src1 (
        .en(!seq), .areg(ins.rs1), .last_dyn(last_dyn), .f(f), .j(iter),
        .idx(s1_idx), .ext(s1_x)
    );
    lagg_remap #(.FW(FW)) u_src2 (
        .en(!seq), .areg(ins.rs2), .last_dyn(last_dyn), .f(f), .j(iter),
        .idx(s2_idx), .ext(s2_x)
    );

    always_comb begin
        is_idx      = !seq && (ins.op == OP_INDEX);
        slot.op     = is_idx ? OP_SETI : ins.op;
        slot.dst    = d_idx;
        slot.src1   = s1_idx;
        slot.src2   = s2_idx;
        slot.dst_x  = d_x;
        slot.src1_x = s1_x;
        slot.src2_x = s2_x;
        slot.imm    = is_idx ? IMM_W'(iter) : ins.imm;
    end
endmodule

// File: rtl/lagg_iter_unit.sv
module lagg_iter_unit
    import lagg_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int MAX_F    = 16,
    parameter int NUM_XREG = 64,
    localparam int FW = $clog2(MAX_F + 1),
    localparam int IW = $clog2(MAX_F),
    localparam int LW = $clog2(LANES + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [AREG_W-1:0]                 cfg_last_dyn,
    input  logic [LW-1:0]                     cfg_par_limit,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic                              in_seq,
    input  logic [OP_W-1:0]                   in_op,
    input  logic [AREG_W-1:0]                 in_rd,
    input  logic [AREG_W-1:0]                 in_rs1,
    input  logic [AREG_W-1:0]                 in_rs2,
    input  logic [IMM_W-1:0]                  in_imm,
    input  logic [FW-1:0]                     in_factor,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic [LANES-1:0]                  out_lane_vld,
    output logic [LANES-1:0][OP_W-1:0]        out_op,
    output logic [LANES-1:0][XREG_W-1:0]      out_dst,
    output logic [LANES-1:0][XREG_W-1:0]      out_src1,
    output logic [LANES-1:0][XREG_W-1:0]      out_src2,
    output logic [LANES-1:0]                  out_dst_x,
    output logic [LANES-1:0]                  out_src1_x,
    output logic [LANES-1:0]                  out_src2_x,
    output logic [LANES-1:0][IMM_W-1:0]       out_imm,
    output logic [LANES-1:0][IW-1:0]          out_iter,
    output logic [LANES-1:0]                  out_last
);
    typedef struct packed {
        logic              busy;
        logic              seq;
        logic              single;
        prim_t             ins;
        logic [AREG_W-1:0] last_dyn;
        logic [FW-1:0]     f;
        logic [FW-1:0]     j;
        logic [LW-1:0]     plim;
    } st_t;

    st_t st_d, st_q;

    logic [FW-1:0] f_new;
    logic [FW-1:0] total;
    logic [FW-1:0] rem;
    logic [FW-1:0] par_eff;
    logic [FW-1:0] cnt;
    logic          fire;
    logic          done_beat;
    logic          take;

    lagg_factor #(.MAX_F(MAX_F), .NUM_XREG(NUM_XREG), .FW(FW)) u_factor (
        .last_dyn(cfg_last_dyn),
        .f_req   (in_factor),
        .f_eff   (f_new)
    );

    always_comb begin
        st_d  = st_q;
        total = st_q.single ? FW'(1) : st_q.f;
        rem   = total - st_q.j;

        if (st_q.plim == '0)
            par_eff = FW'(1);
        else if (FW'(st_q.plim) > FW'(LANES))
            par_eff = FW'(LANES);
        else
            par_eff = FW'(st_q.plim);

        cnt       = (rem < par_eff) ? rem : par_eff;
        fire      = st_q.busy && out_ready;
        done_beat = fire && (rem == cnt);
        in_ready  = !st_q.busy || done_beat;
        take      = in_valid && in_ready;

        if (fire) begin
            st_d.j = st_q.j + cnt;
            if (done_beat)
                st_d.busy = 1'b0;
        end

        if (take) begin
            st_d.busy     = 1'b1;
            st_d.seq      = in_seq;
            st_d.single   = in_seq || ((in_op == OP_INDEX) && (in_rd > cfg_last_dyn));
            st_d.ins.op   = in_op;
            st_d.ins.rd   = in_rd;
            st_d.ins.rs1  = in_rs1;
            st_d.ins.rs2  = in_rs2;
            st_d.ins.imm  = in_imm;
            st_d.last_dyn = cfg_last_dyn;
            st_d.f        = f_new;
            st_d.j        = '0;
            st_d.plim     = cfg_par_limit;
        end

        out_valid = st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [FW-1:0] iter_l;
        sec_t          slot;

        assign iter_l = st_q.j + FW'(l);

        lagg_lane #(.FW(FW)) u_lane (
            .ins     (st_q.ins),
            .seq     (st_q.seq),
            .last_dyn(st_q.last_dyn),
            .f       (st_q.f),
            .iter    (iter_l),
            .slot    (slot)
        );

        assign out_lane_vld[l] = st_q.busy && (FW'(l) < cnt);
        assign out_op[l]       = slot.op;
        assign out_dst[l]      = slot.dst;
        assign out_src1[l]     = slot.src1;
        assign out_src2[l]     = slot.src2;
        assign out_dst_x[l]    = slot.dst_x;
        assign out_src1_x[l]   = slot.src1_x;
        assign out_src2_x[l]   = slot.src2_x;
        assign out_imm[l]      = slot.imm;
        assign out_iter[l]     = iter_l[IW-1:0];
        assign out_last[l]     = out_lane_vld[l] && (iter_l == total - FW'(1));
    end
endmodule

// File: rtl/lagg_iter_chk.sv
module lagg_iter_chk #(
    parameter int LANES = 4,
    parameter int IW    = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [LANES-1:0]         out_lane_vld,
    input logic [LANES-1:0]         out_last,
    input logic [LANES-1:0][IW-1:0] out_iter
);
    logic [IW:0]      exp_iter_q;
    logic [LANES-1:0] last_v;
    logic [LANES-1:0] top_v;

    assign last_v = out_lane_vld & out_last;
    assign top_v  = out_lane_vld & ~(out_lane_vld >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            exp_iter_q <= '0;
        else if (out_valid && out_ready) begin
            if (|last_v)
                exp_iter_q <= '0;
            else
                exp_iter_q <= exp_iter_q + (IW+1)'($countones(out_lane_vld));
        end
    end

    // R1: copies continue from where the previous beat stopped
    assert_iter_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_iter[0]} == exp_iter_q));

    // R1: at most one last flag, and only in the highest valid lane
    assert_last_place_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (|last_v)) |-> (($countones(last_v) == 1) && (last_v == top_v)));

    // R7: valid lanes packed from lane 0
    assert_lanes_packed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lane_vld[0] && (((out_lane_vld + LANES'(1)) & out_lane_vld) == '0)));

    // R8: no acceptance while a primary is still being expanded
    assert_hold_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && (|last_v))) |-> !in_ready);

    // R8: an accepted primary shows up in the next cycle
    assert_accept_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R9: stalled beat stays put
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_lane_vld) && $stable(out_iter) && $stable(out_last)));

    // R10: nothing presented straight after reset
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind lagg_iter_unit lagg_iter_chk #(.LANES(LANES), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_lane_vld(out_lane_vld),
    .out_last    (out_last),
    .out_iter    (out_iter)
);

// File: tb/lagg_iter_unit_test.sv
module lagg_iter_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int MAX_F = 16;
    localparam int NXR   = 64;
    localparam int FW    = $clog2(MAX_F + 1);
    localparam int IW    = $clog2(MAX_F);
    localparam int LW    = $clog2(LANES + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_last_dyn = 4'd3;
    logic [LW-1:0] cfg_par_limit = LW'(1);
    logic in_valid = 1'b0;
    logic in_ready;
    logic in_seq = 1'b0;
    logic [3:0] in_op = '0, in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic [7:0] in_imm = '0;
    logic [FW-1:0] in_factor = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [LANES-1:0] out_lane_vld, out_dst_x, out_src1_x, out_src2_x, out_last;
    logic [LANES-1:0][3:0] out_op;
    logic [LANES-1:0][5:0] out_dst, out_src1, out_src2;
    logic [LANES-1:0][7:0] out_imm;
    logic [LANES-1:0][IW-1:0] out_iter;

    lagg_iter_unit #(.LANES(LANES), .MAX_F(MAX_F), .NUM_XREG(NXR)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_last_dyn(cfg_last_dyn), .cfg_par_limit(cfg_par_limit),
        .in_valid(in_valid), .in_ready(in_ready), .in_seq(in_seq), .in_op(in_op),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_imm(in_imm), .in_factor(in_factor),
        .out_valid(out_valid), .out_ready(out_ready), .out_lane_vld(out_lane_vld),
        .out_op(out_op), .out_dst(out_dst), .out_src1(out_src1), .out_src2(out_src2),
        .out_dst_x(out_dst_x), .out_src1_x(out_src1_x), .out_src2_x(out_src2_x),
        .out_imm(out_imm), .out_iter(out_iter), .out_last(out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int op, dst, dx, s1, s1x, s2, s2x, imm, iter, last, beat_end;
        string tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    int rdy_mode = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int rmap(input int r, input int ld, input bit en, input int f, input int j, output int x);
        x = (en && r <= ld) ? 1 : 0;
        return x ? (r * f + j) : r;
    endfunction

    // reference: expected copies for one accepted primary
    function automatic void push_instr(input bit seq, input int op, input int rd, input int rs1,
                                       input int rs2, input int imm, input int freq,
                                       input int ld, input int plim);
        int cap, f, n, pe;
        bit idx, single;
        cap = NXR / (ld + 1);
        if (cap > MAX_F) cap = MAX_F;
        f = (freq == 0) ? 1 : freq;
        if (f > cap) f = cap;
        pe = (plim == 0) ? 1 : ((plim > LANES) ? LANES : plim);
        idx = !seq && op == 15;
        single = seq || (idx && rd > ld);
        n = single ? 1 : f;
        for (int j = 0; j < n; j++) begin
            exp_t e;
            e.op  = idx ? 14 : op;
            e.dst = rmap(rd, ld, !seq, f, j, e.dx);
            e.s1  = rmap(rs1, ld, !seq, f, j, e.s1x);
            e.s2  = rmap(rs2, ld, !seq, f, j, e.s2x);
            e.imm = idx ? j : imm;
            e.iter = j;
            e.last = (j == n - 1) ? 1 : 0;
            e.beat_end = (e.last == 1 || (j % pe) == pe - 1) ? 1 : 0;
            e.tag = seq ? "R6" : (idx ? (single ? "R5" : "R4") : "R2");
            q.push_back(e);
        end
    endfunction

    // per-cycle comparison against the reference queue
    bit prev_stall = 0;
    logic [LANES-1:0][IW-1:0] prev_iter;
    logic [LANES-1:0][5:0] prev_dst;
    logic [LANES-1:0] prev_vld;

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk(out_valid == (q.size() != 0), "R8", "out_valid", int'(out_valid), int'(q.size() != 0));
            if (prev_stall)
                chk(out_valid && out_iter == prev_iter && out_dst == prev_dst && out_lane_vld == prev_vld,
                    "R9", "stalled beat changed iter0", int'(out_iter[0]), int'(prev_iter[0]));
            prev_stall = out_valid && !out_ready;
            prev_iter = out_iter;
            prev_dst = out_dst;
            prev_vld = out_lane_vld;
            if (out_valid && out_ready && q.size() != 0) begin
                int l;
                bit fin;
                l = 0;
                fin = 0;
                while (!fin && q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    if (l < LANES) begin
                        chk(out_lane_vld[l] == 1'b1, "R7", "lane valid", int'(out_lane_vld[l]), 1);
                        chk(int'(out_iter[l]) == e.iter, "R1", "iteration", int'(out_iter[l]), e.iter);
                        chk(int'(out_last[l]) == e.last, "R1", "last flag", int'(out_last[l]), e.last);
                        chk(int'(out_op[l]) == e.op, e.tag, "opcode", int'(out_op[l]), e.op);
                        chk(int'(out_imm[l]) == e.imm, e.tag, "immediate", int'(out_imm[l]), e.imm);
                        chk(int'(out_dst[l]) == e.dst && int'(out_dst_x[l]) == e.dx, e.tag, "dst", int'(out_dst[l]), e.dst);
                        chk(int'(out_src1[l]) == e.s1 && int'(out_src1_x[l]) == e.s1x, e.tag, "src1", int'(out_src1[l]), e.s1);
                        chk(int'(out_src2[l]) == e.s2 && int'(out_src2_x[l]) == e.s2x, e.tag, "src2", int'(out_src2[l]), e.s2);
                    end else
                        chk(1'b0, "R7", "beat wider than lanes", l, LANES - 1);
                    l++;
                    fin = (e.beat_end == 1);
                end
                for (int k = l; k < LANES; k++)
                    chk(out_lane_vld[k] == 1'b0, "R7", "extra lane valid", int'(out_lane_vld[k]), 0);
                chk(in_ready == (q.size() == 0), "R8", "in_ready on final beat", int'(in_ready), int'(q.size() == 0));
            end else if (out_valid) begin
                chk(in_ready == 1'b0, "R8", "in_ready during expansion", int'(in_ready), 0);
            end
            if (in_valid && in_ready)
                push_instr(in_seq, int'(in_op), int'(in_rd), int'(in_rs1), int'(in_rs2),
                           int'(in_imm), int'(in_factor), int'(cfg_last_dyn), int'(cfg_par_limit));
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = ($urandom % 4) != 0;
                default: out_ready = 1'b0;
            endcase
        end
    end

    task automatic send(input bit seq, input int op, input int rd, input int rs1, input int rs2,
                        input int imm, input int f);
        bit got;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_seq = seq;
        in_op = 4'(op);
        in_rd = 4'(rd);
        in_rs1 = 4'(rs1);
        in_rs2 = 4'(rs2);
        in_imm = 8'(imm);
        in_factor = FW'(f);
        got = 0;
        while (!got) begin
            @(negedge clk);
            got = in_ready;
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && q.size() != 0; i++)
            @(posedge clk);
        @(posedge clk);
        @(posedge clk);
    endtask

    task automatic set_cfg(input int ld, input int plim);
        drain();
        #1;
        cfg_last_dyn = 4'(ld);
        cfg_par_limit = LW'(plim);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R10: idle in and after reset
        repeat (3) @(negedge clk);
        chk(!out_valid && in_ready, "R10", "state during reset", int'(out_valid), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R10", "state after reset", int'(out_valid), 0);

        // R1 R2: plain vector op, one copy per beat
        set_cfg(3, 1);
        send(0, 2, 2, 1, 9, 33, 4);
        // R4: index init on a dynamic register
        send(0, 15, 0, 0, 0, 0, 4);
        // R5: index init on a static register
        send(0, 15, 10, 0, 0, 0, 4);
        // R6: sequence instruction in between
        send(1, 3, 2, 1, 12, 77, 4);
        send(0, 4, 3, 12, 0, 5, 4);

        // R3: factor limits
        set_cfg(3, 4);
        send(0, 1, 1, 3, 14, 1, 20);
        send(0, 1, 1, 3, 14, 1, 0);
        set_cfg(7, 4);
        send(0, 5, 7, 6, 8, 2, 12);
        set_cfg(15, 4);
        send(0, 15, 15, 0, 0, 0, 16);
        send(0, 6, 15, 14, 0, 9, 3);

        // R7: parallelism bounds
        set_cfg(2, 3);
        send(0, 7, 2, 1, 5, 0, 10);
        set_cfg(2, 0);
        send(0, 7, 0, 1, 2, 0, 5);
        set_cfg(2, 7);
        send(0, 7, 1, 2, 3, 0, 10);

        // R9: long stall with a beat pending
        set_cfg(3, 2);
        rdy_mode = 2;
        send(0, 8, 1, 2, 0, 4, 6);
        repeat (6) @(posedge clk);
        rdy_mode = 0;
        drain();

        // R8: back-to-back traffic with throttled consumer
        set_cfg(5, 3);
        rdy_mode = 1;
        for (int i = 0; i < 60; i++)
            send(($urandom % 5) == 0, int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
                 int'($urandom % 16), int'($urandom % 256), int'($urandom % 20));
        drain();
        rdy_mode = 0;
        set_cfg(0, 4);
        for (int i = 0; i < 20; i++)
            send(0, int'($urandom % 16), int'($urandom % 2), int'($urandom % 16),
                 int'($urandom % 16), int'($urandom % 256), int'($urandom % 20));
        drain();
        chk(q.size() == 0, "R1", "leftover expected copies", q.size(), 0);
        finish_run();
    end
endmodule